// File: doc/BRIEF.md
# Per-CPU Masked Device Interrupt Router

This block gathers up to 64 device interrupt request lines into one shared request vector and routes them to four CPUs. Each CPU owns a 64-bit enable mask. The CPU's pending vector is the bitwise AND of its mask with the shared request vector. The CPU's interrupt output is asserted whenever any bit of that pending vector is set. Interrupt sources raise or drop a line by presenting its number on a set or a clear strobe. Each time a mask or the request vector changes, the pending vectors are recomputed. Single-cycle post and withdraw pulses then tell the CPU side when a pending bit has appeared or disappeared.

Software reaches the block through a register port that allows only full 64-bit accesses. The register number is the byte offset shifted right by six, so registers sit 64 bytes apart. The masks can be read and written. The pending vectors and the shared request vector can only be read. A fixed control word and four address-array words read as zero. Every access is answered one cycle later with an acknowledge, read data and an error flag.

Top module: `irqr_router`

## Requirements
- R1: After reset, every mask, every pending vector and the request vector are zero, all CPU interrupt outputs and pulses are low, and reads of those registers return zero.
- R2: A set strobe with number n makes bit n of the request vector one. The request vector reads at register number 24.
- R3: The pending vector of CPU c equals mask c AND the request vector. It reads at register number 16+c and takes its new value on the same clock edge that captures the mask or request change.
- R4: cpu_irq[c] is the OR of all bits of CPU c's pending vector. It changes on the same edge as the pending vector.
- R5: A clear strobe for a line whose request bit is already zero changes nothing. When set and clear name lines in the same cycle, the clear is applied first and the set second.
- R6: cpu_post[c] pulses for one cycle when a bit of CPU c's pending vector goes from zero to one. cpu_wdraw[c] pulses for one cycle when such a bit goes from one to zero. Both pulses are aligned with the pending update.
- R7: A 64-bit write to register number 8+c loads mask c, and a read returns it.
- R8: The register number is reg_addr shifted right by 6. The low six address bits do not affect the access.
- R9: reg_size encodes log2 of the access bytes, and only code 3 (64-bit) is legal. Any other code returns zero data, raises reg_err and changes no state.
- R10: A write to any register other than a mask raises reg_err and changes no state. This covers the pending vectors, the request vector, the control word and the address-array words.
- R11: Register number 0 (control word) and register numbers 1 to 4 (address-array words) read as zero without an error.
- R12: A read of any other register number returns zero and raises reg_err for one cycle.
- R13: Every request is answered by reg_ack exactly one cycle later, and reg_err is only ever high together with reg_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_vld | input | 1 | Raise a device request line |
| set_num | input | 6 | Line number to raise |
| clr_vld | input | 1 | Drop a device request line |
| clr_num | input | 6 | Line number to drop |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset into the register window |
| reg_size | input | 2 | log2 of the access size in bytes |
| reg_wdata | input | 64 | Write data |
| reg_ack | output | 1 | Access answered (one cycle after request) |
| reg_rdata | output | 64 | Read data |
| reg_err | output | 1 | Access error |
| cpu_irq | output | 4 | Device interrupt level per CPU |
| cpu_post | output | 4 | Pulse: a pending bit appeared for the CPU |
| cpu_wdraw | output | 4 | Pulse: a pending bit disappeared for the CPU |

## Verification
A corrupted mask, request or pending bit shows up at the ports on the edge after the next line event. It appears as a wrong cpu_irq level or a missing post or withdraw pulse. It also appears in the data of the next read of the affected register, one cycle after that read is requested. The bench therefore raises each of the 64 lines in turn under four distinct masks and checks every CPU's level and pending read-back each time. It also sweeps the whole register-number space and every access size, so a decode error appears as wrong data or a wrong error flag on that same access.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int REGNUM_SHIFT = 6;

  typedef enum logic [1:0] {
    ACC_8  = 2'd0,
    ACC_16 = 2'd1,
    ACC_32 = 2'd2,
    ACC_64 = 2'd3
  } acc_size_e;

  localparam int RN_CTRL      = 0;
  localparam int RN_ADDR_BASE = 1;
  localparam int RN_ADDR_CNT  = 4;
  localparam int RN_MASK_BASE = 8;
  localparam int RN_PEND_BASE = 16;
  localparam int RN_RAW       = 24;
endpackage

// File: rtl/irqr_reqvec.sv
module irqr_reqvec #(
  parameter int NIRQ = 64,
  localparam int IW = $clog2(NIRQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_vld,
  input  logic [IW-1:0]   set_num,
  input  logic            clr_vld,
  input  logic [IW-1:0]   clr_num,
  output logic [NIRQ-1:0] raw_q,
  output logic [NIRQ-1:0] raw_d,
  output logic            raw_en
);
  always_comb begin
    raw_d = raw_q;
    if (clr_vld) raw_d[clr_num] = 1'b0;
    if (set_vld) raw_d[set_num] = 1'b1;
    raw_en = set_vld | clr_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end
endmodule

// File: rtl/irqr_cpu_slice.sv
module irqr_cpu_slice #(
  parameter int NIRQ = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] raw_d,
  input  logic            raw_en,
  input  logic            mask_we,
  input  logic [NIRQ-1:0] wdata,
  output logic [NIRQ-1:0] mask_q,
  output logic [NIRQ-1:0] pend_q,
  output logic            irq,
  output logic            post,
  output logic            wdraw
);
  logic [NIRQ-1:0] mask_d, pend_d;
  logic            upd, post_d, wdraw_d;

  always_comb begin
    mask_d  = mask_we ? wdata : mask_q;
    pend_d  = mask_d & raw_d;
    upd     = mask_we | raw_en;
    post_d  = upd & (|(pend_d & ~pend_q));
    wdraw_d = upd & (|(pend_q & ~pend_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
      post   <= 1'b0;
      wdraw  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_d;
      if (upd)     pend_q <= pend_d;
      post  <= post_d;
      wdraw <= wdraw_d;
    end
  end

  assign irq = |pend_q;
endmodule

// File: rtl/irqr_regport.sv
module irqr_regport
  import irqr_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NIRQ = 64,
  parameter int AW   = 12,
  localparam int RNW = AW - REGNUM_SHIFT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req,
  input  logic                      wr,
  input  logic [AW-1:0]             addr,
  input  logic [1:0]                size,
  input  logic [NIRQ-1:0]           wdata,
  input  logic [NCPU-1:0][NIRQ-1:0] mask_q,
  input  logic [NCPU-1:0][NIRQ-1:0] pend_q,
  input  logic [NIRQ-1:0]           raw_q,
  output logic [NCPU-1:0]           mask_we,
  output logic                      ack,
  output logic [NIRQ-1:0]           rdata,
  output logic                      err
);
  logic [RNW-1:0]  regnum;
  logic [NIRQ-1:0] rd_d;
  logic            err_d, legal, mapped, is_mask;

  assign regnum = addr[AW-1:REGNUM_SHIFT];
  assign legal  = (size == ACC_64);

  always_comb begin
    rd_d    = '0;
    err_d   = 1'b0;
    mask_we = '0;
    mapped  = 1'b0;
    is_mask = 1'b0;
    if (regnum == RNW'(RN_CTRL)) mapped = 1'b1;
    for (int a = 0; a < RN_ADDR_CNT; a++)
      if (regnum == RNW'(RN_ADDR_BASE + a)) mapped = 1'b1;
    if (regnum == RNW'(RN_RAW)) begin
      mapped = 1'b1;
      rd_d   = raw_q;
    end
    for (int c = 0; c < NCPU; c++) begin
      if (regnum == RNW'(RN_MASK_BASE + c)) begin
        mapped  = 1'b1;
        is_mask = 1'b1;
        rd_d    = mask_q[c];
        if (req && wr && legal) mask_we[c] = 1'b1;
      end
      if (regnum == RNW'(RN_PEND_BASE + c)) begin
        mapped = 1'b1;
        rd_d   = pend_q[c];
      end
    end
    if (!legal || wr)  rd_d = '0;
    if (!legal)        err_d = req;
    else if (wr)       err_d = req & ~is_mask;
    else               err_d = req & ~mapped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= req;
      err <= err_d;
      if (req) rdata <= rd_d;
    end
  end
endmodule

// File: rtl/irqr_router.sv
module irqr_router
  import irqr_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NIRQ = 64,
  parameter int AW   = 12,
  localparam int IW  = $clog2(NIRQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_vld,
  input  logic [IW-1:0]   set_num,
  input  logic            clr_vld,
  input  logic [IW-1:0]   clr_num,
  input  logic            reg_req,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [1:0]      reg_size,
  input  logic [NIRQ-1:0] reg_wdata,
  output logic            reg_ack,
  output logic [NIRQ-1:0] reg_rdata,
  output logic            reg_err,
  output logic [NCPU-1:0] cpu_irq,
  output logic [NCPU-1:0] cpu_post,
  output logic [NCPU-1:0] cpu_wdraw
);
  logic [1:0]                rst_pipe;
  logic                      rst_s;
  logic [NIRQ-1:0]           raw_q, raw_d;
  logic                      raw_en;
  logic [NCPU-1:0][NIRQ-1:0] mask_q, pend_q;
  logic [NCPU-1:0]           mask_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  irqr_reqvec #(.NIRQ(NIRQ)) u_req (
    .clk(clk), .rst_n(rst_s),
    .set_vld(set_vld), .set_num(set_num),
    .clr_vld(clr_vld), .clr_num(clr_num),
    .raw_q(raw_q), .raw_d(raw_d), .raw_en(raw_en)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    irqr_cpu_slice #(.NIRQ(NIRQ)) u_slice (
      .clk(clk), .rst_n(rst_s),
      .raw_d(raw_d), .raw_en(raw_en),
      .mask_we(mask_we[c]), .wdata(reg_wdata),
      .mask_q(mask_q[c]), .pend_q(pend_q[c]),
      .irq(cpu_irq[c]), .post(cpu_post[c]), .wdraw(cpu_wdraw[c])
    );
  end

  irqr_regport #(.NCPU(NCPU), .NIRQ(NIRQ), .AW(AW)) u_port (
    .clk(clk), .rst_n(rst_s),
    .req(reg_req), .wr(reg_wr), .addr(reg_addr), .size(reg_size),
    .wdata(reg_wdata), .mask_q(mask_q), .pend_q(pend_q), .raw_q(raw_q),
    .mask_we(mask_we), .ack(reg_ack), .rdata(reg_rdata), .err(reg_err)
  );
endmodule

// File: rtl/irqr_router_chk.sv
module irqr_router_chk #(
  parameter int NCPU = 4,
  parameter int NIRQ = 64,
  parameter int AW   = 12,
  localparam int IW  = $clog2(NIRQ)
) (
  input logic                      clk,
  input logic                      rst_s,
  input logic                      set_vld,
  input logic [IW-1:0]             set_num,
  input logic                      clr_vld,
  input logic [IW-1:0]             clr_num,
  input logic                      reg_req,
  input logic                      reg_wr,
  input logic [AW-1:0]             reg_addr,
  input logic [1:0]                reg_size,
  input logic [NIRQ-1:0]           reg_wdata,
  input logic                      reg_ack,
  input logic                      reg_err,
  input logic [NCPU-1:0]           cpu_irq,
  input logic [NCPU-1:0]           cpu_post,
  input logic [NCPU-1:0]           cpu_wdraw,
  input logic [NIRQ-1:0]           raw_q,
  input logic [NCPU-1:0][NIRQ-1:0] mask_q,
  input logic [NCPU-1:0][NIRQ-1:0] pend_q
);
  logic [AW-7:0] rn;
  assign rn = reg_addr[AW-1:6];

  assert_set_line_R2: assert property (@(posedge clk) disable iff (!rst_s)
    set_vld |=> raw_q[$past(set_num)]);

  assert_spurious_clear_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (clr_vld && !set_vld && !raw_q[clr_num]) |=> (raw_q == $past(raw_q)));

  assert_narrow_err_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_req && reg_size != 2'd3) |=> (reg_err && reg_ack));

  assert_ro_write_err_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_req && reg_wr && reg_size == 2'd3 && rn >= (AW-6)'(16)) |=> reg_err);

  assert_err_with_ack_R13: assert property (@(posedge clk) disable iff (!rst_s)
    reg_err |-> reg_ack);

  assert_ack_follows_R13: assert property (@(posedge clk) disable iff (!rst_s)
    reg_req |=> reg_ack);

  for (genvar c = 0; c < NCPU; c++) begin : g_c
    assert_pend_in_mask_R3: assert property (@(posedge clk) disable iff (!rst_s)
      (pend_q[c] & ~mask_q[c]) == '0);
    assert_post_level_R6: assert property (@(posedge clk) disable iff (!rst_s)
      cpu_post[c] |-> cpu_irq[c]);
    assert_zero_mask_quiet_R4: assert property (@(posedge clk) disable iff (!rst_s)
      (reg_req && reg_wr && reg_size == 2'd3 && rn == (AW-6)'(8 + c) && reg_wdata == '0)
        |=> !cpu_irq[c]);
  end
endmodule

bind irqr_router irqr_router_chk #(.NCPU(NCPU), .NIRQ(NIRQ), .AW(AW)) u_chk (
  .clk(clk), .rst_s(rst_s),
  .set_vld(set_vld), .set_num(set_num), .clr_vld(clr_vld), .clr_num(clr_num),
  .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_size(reg_size),
  .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_err(reg_err),
  .cpu_irq(cpu_irq), .cpu_post(cpu_post), .cpu_wdraw(cpu_wdraw),
  .raw_q(raw_q), .mask_q(mask_q), .pend_q(pend_q)
);

// File: tb/tb_irqr_router.sv
module tb_irqr_router;
  localparam int NCPU = 4;
  localparam int NIRQ = 64;
  localparam int AW   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_vld = 1'b0, clr_vld = 1'b0;
  logic [5:0] set_num = '0, clr_num = '0;
  logic reg_req = 1'b0, reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [1:0] reg_size = 2'd3;
  logic [NIRQ-1:0] reg_wdata = '0;
  logic reg_ack, reg_err;
  logic [NIRQ-1:0] reg_rdata;
  logic [NCPU-1:0] cpu_irq, cpu_post, cpu_wdraw;

  int checks = 0, fails = 0;
  logic [NIRQ-1:0] m_mask [NCPU];
  logic [NIRQ-1:0] m_raw;
  logic [NIRQ-1:0] rd;
  logic er, ak;

  always #4 clk = ~clk;

  irqr_router #(.NCPU(NCPU), .NIRQ(NIRQ), .AW(AW)) dut (.*);

  task automatic chk(input string req, input logic [NIRQ-1:0] act, input logic [NIRQ-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input int rn, input int low, input logic [1:0] sz,
                        input logic [NIRQ-1:0] wd);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = wr; reg_addr = AW'((rn << 6) | low);
    reg_size = sz; reg_wdata = wd;
    @(negedge clk);
    rd = reg_rdata; er = reg_err; ak = reg_ack;
    reg_req = 1'b0; reg_wr = 1'b0;
    chk("R13 ack", {63'd0, ak}, 64'd1);
  endtask

  task automatic line(input logic sv, input int sn, input logic cv, input int cn);
    @(negedge clk);
    set_vld = sv; set_num = 6'(sn); clr_vld = cv; clr_num = 6'(cn);
    @(negedge clk);
    set_vld = 1'b0; clr_vld = 1'b0;
    if (cv) m_raw[cn] = 1'b0;
    if (sv) m_raw[sn] = 1'b1;
  endtask

  function automatic logic [NIRQ-1:0] exp_read(input int rn);
    if (rn >= 8 && rn < 8 + NCPU)   return m_mask[rn-8];
    if (rn >= 16 && rn < 16 + NCPU) return m_mask[rn-16] & m_raw;
    if (rn == 24)                   return m_raw;
    return '0;
  endfunction

  function automatic logic exp_err(input int rn);
    return !((rn <= 4) || (rn >= 8 && rn < 8 + NCPU) || (rn >= 16 && rn < 16 + NCPU) || rn == 24);
  endfunction

  task automatic check_irq(input string req);
    logic [NCPU-1:0] e;
    for (int c = 0; c < NCPU; c++) e[c] = |(m_mask[c] & m_raw);
    chk(req, {60'd0, cpu_irq}, {60'd0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_raw = '0;
    for (int c = 0; c < NCPU; c++) m_mask[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {60'd0, cpu_irq}, 64'd0);
    chk("R1 pulses", {56'd0, cpu_post, cpu_wdraw}, 64'd0);
    for (int rn = 8; rn <= 24; rn++) begin
      if (rn < 12 || (rn >= 16 && rn < 20) || rn == 24) begin
        access(1'b0, rn, 0, 2'd3, '0);
        chk("R1 reg zero", rd, '0);
      end
    end

    // R7 R8 mask writes with nonzero low address bits
    m_mask[0] = 64'hAAAA_AAAA_AAAA_AAAA;
    m_mask[1] = 64'h5555_5555_5555_5555;
    m_mask[2] = 64'hFFFF_0000_FFFF_0000;
    m_mask[3] = 64'h8000_0000_0000_0001;
    for (int c = 0; c < NCPU; c++) begin
      access(1'b1, 8 + c, 6'h2A - c, 2'd3, m_mask[c]);
      chk("R7 write no err", {63'd0, er}, 64'd0);
      access(1'b0, 8 + c, 6'h3F, 2'd3, '0);
      chk("R7 R8 mask readback", rd, m_mask[c]);
    end

    // R2 R3 R4 per-line sweep
    for (int n = 0; n < NIRQ; n++) begin
      line(1'b1, n, 1'b0, 0);
      check_irq("R4 irq after set");
      access(1'b0, 24, 0, 2'd3, '0);
      chk("R2 raw", rd, m_raw);
      for (int c = 0; c < NCPU; c++) begin
        access(1'b0, 16 + c, n & 63, 2'd3, '0);
        chk("R3 pending", rd, m_mask[c] & m_raw);
      end
      line(1'b0, 0, 1'b1, n);
      check_irq("R4 irq after clear");
    end

    // R5 spurious clear and same-cycle set/clear ordering
    line(1'b1, 7, 1'b0, 0);
    line(1'b0, 0, 1'b1, 9);
    access(1'b0, 24, 0, 2'd3, '0);
    chk("R5 spurious clear", rd, 64'h80);
    check_irq("R5 irq unchanged");
    line(1'b1, 12, 1'b1, 12);
    access(1'b0, 24, 0, 2'd3, '0);
    chk("R5 set wins", rd, 64'h1080);

    // R6 post and withdraw pulses via mask writes
    access(1'b1, 8, 0, 2'd3, '0);
    m_mask[0] = '0;
    chk("R6 withdraw pulse", {60'd0, cpu_wdraw}, 64'h1);
    chk("R4 cpu0 low", {63'd0, cpu_irq[0]}, 64'd0);
    @(negedge clk);
    chk("R6 withdraw single", {60'd0, cpu_wdraw}, 64'd0);
    access(1'b1, 8, 0, 2'd3, 64'h1000);
    m_mask[0] = 64'h1000;
    chk("R6 post pulse", {60'd0, cpu_post}, 64'h1);
    check_irq("R4 cpu0 high");
    @(negedge clk);
    chk("R6 post single", {60'd0, cpu_post}, 64'd0);

    // R9 narrow sizes
    for (int s = 0; s < 3; s++) begin
      access(1'b0, 8, 0, 2'(s), '0);
      chk("R9 narrow read err", {63'd0, er}, 64'd1);
      chk("R9 narrow read data", rd, '0);
      access(1'b1, 8, 0, 2'(s), 64'hDEAD);
      chk("R9 narrow write err", {63'd0, er}, 64'd1);
      access(1'b0, 8, 0, 2'd3, '0);
      chk("R9 mask unchanged", rd, m_mask[0]);
    end

    // R10 writes outside the masks
    for (int rn = 0; rn < 32; rn++) begin
      if (!(rn >= 8 && rn < 8 + NCPU)) begin
        access(1'b1, rn, 0, 2'd3, '1);
        chk("R10 write err", {63'd0, er}, 64'd1);
      end
    end
    access(1'b0, 24, 0, 2'd3, '0);
    chk("R10 raw unchanged", rd, m_raw);
    access(1'b0, 16, 0, 2'd3, '0);
    chk("R10 pending unchanged", rd, m_mask[0] & m_raw);
    check_irq("R10 irq unchanged");

    // R11 R12 full register sweep
    for (int rn = 0; rn < 64; rn++) begin
      access(1'b0, rn, 8, 2'd3, '0);
      chk(rn <= 4 ? "R11 fixed zero" : "R12 read data", rd, exp_read(rn));
      chk("R12 err flag", {63'd0, er}, {63'd0, exp_err(rn)});
    end
    @(negedge clk);
    chk("R12 err one cycle", {62'd0, reg_ack, reg_err}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule